// File: doc/BRIEF.md
# Seconds counter RTC with match alarm

This block is a memory-mapped real-time clock. It sits on an APB-style register bus and holds a 32-bit count of seconds. A prescaler divides the bus clock into a one-cycle tick once per second, and the count advances on that tick. When the count reaches the limit of 32 bits, it wraps to zero.

Software can set the time by writing a load value. It can program a match value and read back the live count, the match value, the last load value and the alarm status. When the count equals the match value, a sticky status bit sets. The interrupt output is a level that follows that bit. Only reset clears it. A write to the match or load register compares the two at once, so an alarm that is already due is caught in the same bus operation. A small read-only set of identification bytes sits at the top of the 4 KB window, one byte per 32-bit word.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, match, load and status registers read 0 and `irq` is low.
- R2: The count at word offset 0x00 increases by exactly one every `TICKS_PER_SEC` bus clocks and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x0C sets the live count to the written value, and that value reads back at 0x0C. The prescaler restarts, so the next increment comes `TICKS_PER_SEC` clocks after the write.
- R4: A write to offset 0x04 stores the match value, and it reads back at 0x04.
- R5: When an increment brings the count equal to the match value, bit 0 of offset 0x08 becomes 1. `irq` is high whenever that bit is 1.
- R6: A write to 0x04 or 0x0C that leaves the count equal to the match value sets the status in that same operation. The status is visible from the cycle after the write.
- R7: The status bit and `irq` stay at 1 until reset. Writes to offset 0x08 are ignored.
- R8: Offset 0x10 always reads 1. Writes to it have no effect.
- R9: Writes to offset 0x00 are ignored and leave the count unchanged.
- R10: Word reads from 0xFE0 to 0xFFC return, zero-extended and in address order, the bytes 0x30, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address within the 4 KB window, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| irq | output | 1 | Level interrupt, equal to the sticky alarm status |

## Verification
A prescaler that does not restart on load shows up as a count one second ahead. The read starts a few clocks after the load, and in that window a correct design has not yet ticked. A missed or early compare shows within one second of the programmed match. It appears as a status read of 0 when 1 is expected, or as `irq` rising without cause. Because the status is sticky, any false set is still visible at every later read until the next reset. The bench therefore resets between the alarm scenarios.

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          irq
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned WW = AW - 2;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [WW-1:0] W_COUNT = WW'(0);
  localparam logic [WW-1:0] W_MATCH = WW'(1);
  localparam logic [WW-1:0] W_STAT  = WW'(2);
  localparam logic [WW-1:0] W_LOAD  = WW'(3);
  localparam logic [WW-1:0] W_CTRL  = WW'(4);

  logic [PW-1:0] presc_q;
  logic [DW-1:0] cnt_q, match_q, load_q, cnt_nx, match_nx;
  logic          stat_q;
  logic [WW-1:0] word;
  logic          wr_en, wr_load, wr_match, tick, hit;

  assign word     = paddr[AW-1:2];
  assign wr_en    = psel & penable & pwrite;
  assign wr_load  = wr_en && (word == W_LOAD);
  assign wr_match = wr_en && (word == W_MATCH);
  assign tick     = (presc_q == PRESC_LAST);

  assign cnt_nx   = wr_load ? pwdata : (tick ? cnt_q + DW'(1) : cnt_q);
  assign match_nx = wr_match ? pwdata : match_q;
  assign hit      = (wr_load | wr_match | tick) && (cnt_nx == match_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
      match_q <= '0;
      load_q  <= '0;
      stat_q  <= 1'b0;
    end else begin
      presc_q <= (wr_load || tick) ? '0 : presc_q + PW'(1);
      cnt_q   <= cnt_nx;
      match_q <= match_nx;
      if (wr_load) load_q <= pwdata;
      stat_q  <= stat_q | hit;
    end
  end

  assign irq = stat_q;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h30;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (word[WW-1:3] == '1)
        prdata = DW'(id_byte(word[2:0]));
      else begin
        case (word)
          W_COUNT: prdata = cnt_q;
          W_MATCH: prdata = match_q;
          W_STAT:  prdata = DW'(stat_q);
          W_LOAD:  prdata = load_q;
          W_CTRL:  prdata = DW'(1);
          default: prdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic [DW-1:0] prdata,
  input logic          irq,
  input logic [DW-1:0] cnt
);
  logic rd_sel, wr_any, wr_ld, wr_mt;
  assign rd_sel = psel && !pwrite;
  assign wr_any = psel && penable && pwrite;
  assign wr_ld  = wr_any && (paddr[AW-1:2] == (AW-2)'(3));
  assign wr_mt  = wr_any && (paddr[AW-1:2] == (AW-2)'(1));

  // R7
  sticky_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);

  // R8
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && paddr == AW'(12'h010)) |-> prdata == DW'(1));

  // R3
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ld |=> cnt == $past(pwdata));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + DW'(1)));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_ld) || $past(wr_mt) || cnt != $past(cnt)));

  // R10
  id_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && paddr == AW'(12'hFE0)) |-> prdata == DW'(8'h30));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel && paddr == AW'(12'h014)) |-> prdata == '0);
endmodule

bind sec_rtc sec_rtc_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .cnt(cnt_q)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  localparam int unsigned TPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_d[$];
  logic        exp_i[$];
  string       exp_t[$];

  sec_rtc #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // monitor: pops one expected item per read access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      n_run++;
      if (exp_d.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: actual %h expected none", prdata);
      end else begin
        logic [31:0] d;
        logic        i;
        string       t;
        d = exp_d.pop_front();
        i = exp_i.pop_front();
        t = exp_t.pop_front();
        if (prdata !== d || irq !== i) begin
          n_fail++;
          $display("FAIL %s: actual data %h irq %b, expected data %h irq %b",
                   t, prdata, irq, d, i);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] v);
    @(posedge clk); #1 psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = v;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] d,
                    input logic i, input string tag);
    exp_d.push_back(d); exp_i.push_back(i); exp_t.push_back(tag);
    @(posedge clk); #1 psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(12'h000, 32'h0, 1'b0, "R1 count");
    rd(12'h004, 32'h0, 1'b0, "R1 match");
    rd(12'h008, 32'h0, 1'b0, "R1 status");
    rd(12'h00C, 32'h0, 1'b0, "R1 load");

    // R10 identification bytes
    rd(12'hFE0, 32'h30, 1'b0, "R10 id0");
    rd(12'hFE4, 32'h10, 1'b0, "R10 id1");
    rd(12'hFE8, 32'h04, 1'b0, "R10 id2");
    rd(12'hFEC, 32'h00, 1'b0, "R10 id3");
    rd(12'hFF0, 32'h0D, 1'b0, "R10 id4");
    rd(12'hFF4, 32'hF0, 1'b0, "R10 id5");
    rd(12'hFF8, 32'h05, 1'b0, "R10 id6");
    rd(12'hFFC, 32'hB1, 1'b0, "R10 id7");
    // R11 unmapped
    rd(12'h014, 32'h0, 1'b0, "R11 0x014");
    rd(12'h800, 32'h0, 1'b0, "R11 0x800");
    rd(12'hFDC, 32'h0, 1'b0, "R11 0xFDC");

    // R8 control
    wr(12'h010, 32'h0);
    rd(12'h010, 32'h1, 1'b0, "R8 control");
    // R9 count is read only
    wr(12'h00C, 32'h1234);
    wr(12'h000, 32'h55);
    rd(12'h000, 32'h1234, 1'b0, "R9 count write ignored");
    // R7 status write ignored
    wr(12'h008, 32'h1);
    rd(12'h008, 32'h0, 1'b0, "R7 status write ignored");

    // R2 wrap, R4 match readback, R3 load readback
    wr(12'h004, 32'h10);
    wr(12'h00C, 32'hFFFF_FFFE);
    idle(20);
    rd(12'h000, 32'h0, 1'b0, "R2 wrap after two seconds");
    rd(12'h00C, 32'hFFFF_FFFE, 1'b0, "R3 load readback");
    rd(12'h004, 32'h10, 1'b0, "R4 match readback");

    // R3 prescaler restart on load
    wr(12'h00C, 32'h500);
    wr(12'h00C, 32'h600);
    idle(3);
    rd(12'h000, 32'h600, 1'b0, "R3 no early increment");
    rd(12'h000, 32'h601, 1'b0, "R3 increment one second after load");

    // R5 alarm by counting, R7 sticky
    wr(12'h004, 32'h100);
    wr(12'h00C, 32'hFE);
    rd(12'h008, 32'h0, 1'b0, "R5 status before match");
    idle(20);
    rd(12'h008, 32'h1, 1'b1, "R5 status after count reaches match");
    idle(20);
    rd(12'h008, 32'h1, 1'b1, "R7 status stays set");
    rd(12'h000, 32'h104, 1'b1, "R2 count keeps running");

    // R6 via match write
    do_reset();
    rd(12'h008, 32'h0, 1'b0, "R1 status cleared by reset");
    wr(12'h00C, 32'h40);
    wr(12'h004, 32'h40);
    rd(12'h008, 32'h1, 1'b1, "R6 match write hits at once");

    // R6 via load write
    do_reset();
    wr(12'h004, 32'h77);
    rd(12'h008, 32'h0, 1'b0, "R6 no hit before load");
    wr(12'h00C, 32'h77);
    rd(12'h008, 32'h1, 1'b1, "R6 load write hits at once");

    idle(4);
    if (exp_d.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending, expected 0", exp_d.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule